// File: doc/BRIEF.md
# Two-Master Fixed-Priority Bus Interconnect

This block joins two bus masters to a small set of slaves over a single shared path. The two masters speak the Wishbone classic handshake and carry 32-bit data. Only one master owns the path at a time. Master 0 always wins over master 1 when the path is free. Once a master owns the path, it keeps it until it drops its cycle signal. The owning master's address is compared against a base and mask pair for each numbered slave. An address that matches no slave goes to a default slave, which sits at the highest index, so a further bridge can hang behind it. Only the selected slave sees cycle and strobe. Only the owning master sees that slave's ack, err, rty and read data.

Arbitration is a three-state machine. `ARB_IDLE` means no owner. It moves to `ARB_OWN0` when master 0 requests, and to `ARB_OWN1` when only master 1 requests. `ARB_OWN0` returns to `ARB_IDLE` when master 0 drops cyc. `ARB_OWN1` returns to `ARB_IDLE` when master 1 drops cyc. Both owner states otherwise hold. A grant therefore takes effect on the clock edge after the request is seen.

Two parameters select variants of the block:
- An optional watchdog turns a strobe that gets no answer into a one-cycle bus error.
- An optional registered mode puts one register stage on the request path. Registered mode supports classic cycles only.

Top module: `prio_bus_xbar`

## Requirements
- R1: While reset is high, and on the first cycle after it with both masters idle, no slave sees cyc or stb, and both masters see ack, err and rty low.
- R2: From `ARB_IDLE`, when both masters raise cyc, master 0 is granted on the next edge and master 1 gets no response.
- R3: A granted master keeps the path while its cyc stays high, even when the other master requests. After it drops cyc, one `ARB_IDLE` cycle passes, in which no slave is strobed, before the other master is granted.
- R4: Numbered slave i is selected when (address AND MASK[i]) equals BASE[i], and the lowest matching index wins. An address that matches no slave selects the default slave at index NUM_SLV. In the bench set-up, address bits 31:28 equal to 0 select slave 0, equal to 1 select slave 1, and any other value selects slave 2.
- R5: cyc and stb reach only the selected slave. Address, write data, we, byte selects and cti are taken from the granted master and are shared by all slaves.
- R6: The selected slave's ack, err, rty and read data go to the granted master only. The other master sees zeros on all four.
- R7: With the watchdog enabled and WDOG_W bits wide, suppose a granted strobe gets no response. Counting the first granted cycle as cycle 0, err is raised to the granted master on cycle 2^WDOG_W-1, for exactly one cycle.
- R8: In registered mode, slave cyc, stb and the shared request fields appear one cycle after the unregistered path would show them. A slave's stb drops on the cycle after that slave responds. Responses return to the master without a register. Only classic cycles (cti = 000) are supported.
- R9: The watchdog count restarts from zero whenever the granted strobe is low or a response arrives. A strobe that is dropped and raised again gets the full 2^WDOG_W-1 cycles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m0_cyc | input | 1 | Master 0 cycle |
| m0_stb | input | 1 | Master 0 strobe |
| m0_we | input | 1 | Master 0 write enable |
| m0_adr | input | AW | Master 0 address |
| m0_wdat | input | DW | Master 0 write data |
| m0_sel | input | DW/8 | Master 0 byte selects |
| m0_cti | input | 3 | Master 0 cycle type |
| m0_ack | output | 1 | Ack to master 0 |
| m0_err | output | 1 | Error to master 0 |
| m0_rty | output | 1 | Retry to master 0 |
| m0_rdat | output | DW | Read data to master 0 |
| m1_cyc | input | 1 | Master 1 cycle |
| m1_stb | input | 1 | Master 1 strobe |
| m1_we | input | 1 | Master 1 write enable |
| m1_adr | input | AW | Master 1 address |
| m1_wdat | input | DW | Master 1 write data |
| m1_sel | input | DW/8 | Master 1 byte selects |
| m1_cti | input | 3 | Master 1 cycle type |
| m1_ack | output | 1 | Ack to master 1 |
| m1_err | output | 1 | Error to master 1 |
| m1_rty | output | 1 | Retry to master 1 |
| m1_rdat | output | DW | Read data to master 1 |
| s_cyc | output | NUM_SLV+1 | Per-slave cycle, default slave at the top index |
| s_stb | output | NUM_SLV+1 | Per-slave strobe |
| s_we | output | 1 | Shared write enable |
| s_adr | output | AW | Shared address |
| s_wdat | output | DW | Shared write data |
| s_sel | output | DW/8 | Shared byte selects |
| s_cti | output | 3 | Shared cycle type |
| s_ack | input | NUM_SLV+1 | Per-slave ack |
| s_err | input | NUM_SLV+1 | Per-slave error |
| s_rty | input | NUM_SLV+1 | Per-slave retry |
| s_rdat | input | (NUM_SLV+1)*DW | Per-slave read data, slave i in bits i*DW +: DW |

## Verification
Some behaviours can be checked on every cycle. These are:
- that at most one slave carries cyc;
- that the two masters never both see ack;
- that an owner keeps the grant while its cyc is high;
- that the watchdog error lasts one cycle and never follows an idle strobe;
- that a registered strobe drops after a response.

Other behaviours only show up in the bench scenarios. These are:
- that every address nibble reaches the right slave with the right read data;
- that master 0 wins a tie;
- that a waiting master 0 is not let in early;
- that the watchdog fires on exactly the expected cycle and restarts when the strobe drops;
- that the registered request path costs one cycle.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_OWN0 = 2'd1,
        ARB_OWN1 = 2'd2
    } arb_state_t;
endpackage

// File: rtl/pbx_arb.sv
module pbx_arb
    import pbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req0,
    input  logic req1,
    output logic gnt0,
    output logic gnt1
);
    arb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (req0)      state_d = ARB_OWN0;
                else if (req1) state_d = ARB_OWN1;
            end
            ARB_OWN0: if (!req0) state_d = ARB_IDLE;
            ARB_OWN1: if (!req1) state_d = ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        gnt0 = (state_q == ARB_OWN0);
        gnt1 = (state_q == ARB_OWN1);
    end

    // R2: master 0 wins from idle
    a_r2_prio_win: assert property (@(posedge clk) disable iff (rst)
        (!gnt0 && !gnt1 && req0) |=> gnt0);
    // R3: ownership is held while cyc stays high
    a_r3_hold0: assert property (@(posedge clk) disable iff (rst)
        (gnt0 && req0) |=> gnt0);
    a_r3_hold1: assert property (@(posedge clk) disable iff (rst)
        (gnt1 && req1) |=> gnt1);
    // R3: release passes through idle
    a_r3_idle_gap: assert property (@(posedge clk) disable iff (rst)
        ((gnt0 && !req0) || (gnt1 && !req1)) |=> (!gnt0 && !gnt1));
endmodule

// File: rtl/pbx_decode.sv
module pbx_decode #(
    parameter int              NUM_SLV = 2,
    parameter int              AW      = 32,
    parameter logic [NUM_SLV*AW-1:0] BASE = {32'h1000_0000, 32'h0000_0000},
    parameter logic [NUM_SLV*AW-1:0] MASK = {32'hF000_0000, 32'hF000_0000}
) (
    input  logic [AW-1:0]    adr,
    output logic [NUM_SLV:0] sel
);
    logic [NUM_SLV-1:0] hit;
    logic               found;

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_match
        assign hit[g] = ((adr & MASK[g*AW +: AW]) == BASE[g*AW +: AW]);
    end

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_SLV; i++) begin
            if (hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        if (!found) sel[NUM_SLV] = 1'b1;
    end
endmodule

// File: rtl/pbx_wdog.sv
module pbx_wdog #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic resp,
    output logic expire
);
    localparam logic [W-1:0] LAST = '1;
    logic [W-1:0] cnt_q;

    assign expire = busy && !resp && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !busy || resp || cnt_q == LAST) cnt_q <= '0;
        else                                       cnt_q <= cnt_q + 1'b1;
    end

    // R7: error lasts a single cycle
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);
    // R9: an idle strobe restarts the count
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !expire);
endmodule

// File: rtl/prio_bus_xbar.sv
module prio_bus_xbar #(
    parameter int NUM_SLV  = 2,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter logic [NUM_SLV*AW-1:0] SLV_BASE = {32'h1000_0000, 32'h0000_0000},
    parameter logic [NUM_SLV*AW-1:0] SLV_MASK = {32'hF000_0000, 32'hF000_0000},
    parameter bit REG_MODE = 1'b0,
    parameter bit WDOG_EN  = 1'b1,
    parameter int WDOG_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    m0_cyc,
    input  logic                    m0_stb,
    input  logic                    m0_we,
    input  logic [AW-1:0]           m0_adr,
    input  logic [DW-1:0]           m0_wdat,
    input  logic [DW/8-1:0]         m0_sel,
    input  logic [2:0]              m0_cti,
    output logic                    m0_ack,
    output logic                    m0_err,
    output logic                    m0_rty,
    output logic [DW-1:0]           m0_rdat,
    input  logic                    m1_cyc,
    input  logic                    m1_stb,
    input  logic                    m1_we,
    input  logic [AW-1:0]           m1_adr,
    input  logic [DW-1:0]           m1_wdat,
    input  logic [DW/8-1:0]         m1_sel,
    input  logic [2:0]              m1_cti,
    output logic                    m1_ack,
    output logic                    m1_err,
    output logic                    m1_rty,
    output logic [DW-1:0]           m1_rdat,
    output logic [NUM_SLV:0]        s_cyc,
    output logic [NUM_SLV:0]        s_stb,
    output logic                    s_we,
    output logic [AW-1:0]           s_adr,
    output logic [DW-1:0]           s_wdat,
    output logic [DW/8-1:0]         s_sel,
    output logic [2:0]              s_cti,
    input  logic [NUM_SLV:0]        s_ack,
    input  logic [NUM_SLV:0]        s_err,
    input  logic [NUM_SLV:0]        s_rty,
    input  logic [(NUM_SLV+1)*DW-1:0] s_rdat
);
    localparam int NS = NUM_SLV + 1;
    localparam int SW = DW / 8;

    logic            gnt0, gnt1;
    logic            c_cyc, c_stb, c_we;
    logic [AW-1:0]   c_adr;
    logic [DW-1:0]   c_wdat;
    logic [SW-1:0]   c_sel;
    logic [2:0]      c_cti;
    logic [NS-1:0]   dec_sel, route;
    logic            pick_ack, pick_err, pick_rty, wd_err;
    logic [DW-1:0]   pick_rdat;

    pbx_arb u_arb (
        .clk (clk), .rst (rst),
        .req0(m0_cyc), .req1(m1_cyc),
        .gnt0(gnt0), .gnt1(gnt1)
    );

    always_comb begin
        c_cyc = 1'b0; c_stb = 1'b0; c_we = 1'b0;
        c_adr = '0; c_wdat = '0; c_sel = '0; c_cti = '0;
        if (gnt0) begin
            c_cyc = m0_cyc; c_stb = m0_stb; c_we = m0_we;
            c_adr = m0_adr; c_wdat = m0_wdat; c_sel = m0_sel; c_cti = m0_cti;
        end else if (gnt1) begin
            c_cyc = m1_cyc; c_stb = m1_stb; c_we = m1_we;
            c_adr = m1_adr; c_wdat = m1_wdat; c_sel = m1_sel; c_cti = m1_cti;
        end
    end

    pbx_decode #(
        .NUM_SLV(NUM_SLV), .AW(AW), .BASE(SLV_BASE), .MASK(SLV_MASK)
    ) u_dec (
        .adr(c_adr), .sel(dec_sel)
    );

    if (REG_MODE) begin : g_reg
        logic [NS-1:0] rsel_q;
        logic          resp_now;
        assign resp_now = |(s_stb & (s_ack | s_err | s_rty));
        always_ff @(posedge clk) begin
            if (rst) begin
                s_cyc <= '0; s_stb <= '0; s_we <= 1'b0; s_adr <= '0;
                s_wdat <= '0; s_sel <= '0; s_cti <= '0; rsel_q <= '0;
            end else begin
                s_cyc  <= {NS{c_cyc}} & dec_sel;
                s_stb  <= {NS{c_stb && !resp_now}} & dec_sel;
                s_we   <= c_we;
                s_adr  <= c_adr;
                s_wdat <= c_wdat;
                s_sel  <= c_sel;
                s_cti  <= c_cti;
                rsel_q <= dec_sel;
            end
        end
        assign route = rsel_q;
        // R8: a responding slave loses its strobe on the next cycle
        a_r8_stb_drop: assert property (@(posedge clk) disable iff (rst)
            resp_now |=> (s_stb == '0));
    end else begin : g_comb
        assign s_cyc  = {NS{c_cyc}} & dec_sel;
        assign s_stb  = {NS{c_stb}} & dec_sel;
        assign s_we   = c_we;
        assign s_adr  = c_adr;
        assign s_wdat = c_wdat;
        assign s_sel  = c_sel;
        assign s_cti  = c_cti;
        assign route  = dec_sel;
        // R5: a slave is strobed only while some master holds cyc and stb
        a_r5_stb_source: assert property (@(posedge clk) disable iff (rst)
            (|s_stb) |-> ((m0_cyc && m0_stb) || (m1_cyc && m1_stb)));
    end

    always_comb begin
        pick_ack  = |(s_ack & route);
        pick_err  = |(s_err & route);
        pick_rty  = |(s_rty & route);
        pick_rdat = '0;
        for (int i = 0; i < NS; i++) begin
            if (route[i]) pick_rdat = pick_rdat | s_rdat[i*DW +: DW];
        end
    end

    if (WDOG_EN) begin : g_wdog
        pbx_wdog #(.W(WDOG_W)) u_wdog (
            .clk(clk), .rst(rst), .busy(c_stb),
            .resp(pick_ack | pick_err | pick_rty), .expire(wd_err)
        );
    end else begin : g_nowdog
        assign wd_err = 1'b0;
    end

    assign m0_ack  = gnt0 & pick_ack;
    assign m0_err  = gnt0 & (pick_err | wd_err);
    assign m0_rty  = gnt0 & pick_rty;
    assign m0_rdat = gnt0 ? pick_rdat : '0;
    assign m1_ack  = gnt1 & pick_ack;
    assign m1_err  = gnt1 & (pick_err | wd_err);
    assign m1_rty  = gnt1 & pick_rty;
    assign m1_rdat = gnt1 ? pick_rdat : '0;

    // R5: at most one slave carries a cycle
    a_r5_one_slave: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_cyc));
    // R6: responses never reach both masters
    a_r6_excl: assert property (@(posedge clk) disable iff (rst)
        !((m0_ack || m0_err || m0_rty) && (m1_ack || m1_err || m1_rty)));
    // R6: an ack always originates at a slave
    a_r6_ack_src: assert property (@(posedge clk) disable iff (rst)
        (m0_ack || m1_ack) |-> (|s_ack));
endmodule

// File: tb/sim_prio_bus_xbar.sv
`timescale 1ns/1ps
module sim_prio_bus_xbar;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        m0_cyc = 0, m0_stb = 0, m0_we = 0;
    logic [31:0] m0_adr = '0, m0_wdat = '0;
    logic [3:0]  m0_sel = '0;
    logic [2:0]  m0_cti = '0;
    logic        m1_cyc = 0, m1_stb = 0, m1_we = 0;
    logic [31:0] m1_adr = '0, m1_wdat = '0;
    logic [3:0]  m1_sel = '0;
    logic [2:0]  m1_cti = '0;

    logic        a_m0_ack, a_m0_err, a_m0_rty, a_m1_ack, a_m1_err, a_m1_rty;
    logic [31:0] a_m0_rdat, a_m1_rdat;
    logic [NS-1:0] a_cyc, a_stb, a_ack, a_err, a_rty;
    logic        a_we;
    logic [31:0] a_adr, a_wdat;
    logic [3:0]  a_sel;
    logic [2:0]  a_cti;
    logic [NS*32-1:0] a_rdat;
    logic [NS-1:0] ack_en = '1, err_en = '0, rty_en = '0;

    logic        b_m0_ack, b_m0_err, b_m0_rty, b_m1_ack, b_m1_err, b_m1_rty;
    logic [31:0] b_m0_rdat, b_m1_rdat;
    logic [NS-1:0] b_cyc, b_stb, b_ack;
    logic        b_we;
    logic [31:0] b_adr, b_wdat;
    logic [3:0]  b_sel;
    logic [2:0]  b_cti;
    logic [NS*32-1:0] b_rdat;

    assign a_ack = a_stb & ack_en;
    assign a_err = a_stb & err_en;
    assign a_rty = a_stb & rty_en;
    assign b_ack = b_stb;
    for (genvar g = 0; g < NS; g++) begin : g_rd
        assign a_rdat[g*32 +: 32] = 32'hC0DE_0000 + g;
        assign b_rdat[g*32 +: 32] = 32'hC0DE_0000 + g;
    end

    prio_bus_xbar u0 (
        .clk(clk), .rst(rst),
        .m0_cyc(m0_cyc), .m0_stb(m0_stb), .m0_we(m0_we), .m0_adr(m0_adr),
        .m0_wdat(m0_wdat), .m0_sel(m0_sel), .m0_cti(m0_cti),
        .m0_ack(a_m0_ack), .m0_err(a_m0_err), .m0_rty(a_m0_rty), .m0_rdat(a_m0_rdat),
        .m1_cyc(m1_cyc), .m1_stb(m1_stb), .m1_we(m1_we), .m1_adr(m1_adr),
        .m1_wdat(m1_wdat), .m1_sel(m1_sel), .m1_cti(m1_cti),
        .m1_ack(a_m1_ack), .m1_err(a_m1_err), .m1_rty(a_m1_rty), .m1_rdat(a_m1_rdat),
        .s_cyc(a_cyc), .s_stb(a_stb), .s_we(a_we), .s_adr(a_adr), .s_wdat(a_wdat),
        .s_sel(a_sel), .s_cti(a_cti), .s_ack(a_ack), .s_err(a_err), .s_rty(a_rty),
        .s_rdat(a_rdat)
    );

    prio_bus_xbar #(.REG_MODE(1'b1), .WDOG_EN(1'b0)) u1 (
        .clk(clk), .rst(rst),
        .m0_cyc(m0_cyc), .m0_stb(m0_stb), .m0_we(m0_we), .m0_adr(m0_adr),
        .m0_wdat(m0_wdat), .m0_sel(m0_sel), .m0_cti(m0_cti),
        .m0_ack(b_m0_ack), .m0_err(b_m0_err), .m0_rty(b_m0_rty), .m0_rdat(b_m0_rdat),
        .m1_cyc(m1_cyc), .m1_stb(m1_stb), .m1_we(m1_we), .m1_adr(m1_adr),
        .m1_wdat(m1_wdat), .m1_sel(m1_sel), .m1_cti(m1_cti),
        .m1_ack(b_m1_ack), .m1_err(b_m1_err), .m1_rty(b_m1_rty), .m1_rdat(b_m1_rdat),
        .s_cyc(b_cyc), .s_stb(b_stb), .s_we(b_we), .s_adr(b_adr), .s_wdat(b_wdat),
        .s_sel(b_sel), .s_cti(b_cti), .s_ack(b_ack), .s_err(3'b000), .s_rty(3'b000),
        .s_rdat(b_rdat)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(a_cyc == 0 && a_stb == 0, "R1 slave strobes in reset", {a_cyc, a_stb}, 0);
        chk(!a_m0_ack && !a_m1_ack && !a_m0_err && !a_m1_err, "R1 responses in reset",
            {a_m0_ack, a_m1_ack, a_m0_err, a_m1_err}, 0);
        @(negedge clk) rst = 1'b0;
        tick();
        chk(a_cyc == 0 && b_cyc == 0, "R1 idle after reset", {a_cyc, b_cyc}, 0);
        chk(!a_m0_rty && !a_m1_rty, "R1 rty after reset", {a_m0_rty, a_m1_rty}, 0);

        // R4 R5 R6: sweep every address nibble from both masters
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 16; n++) begin
                logic [31:0] adr;
                int idx;
                adr = {n[3:0], 28'h00ABC40};
                idx = (n == 0) ? 0 : (n == 1) ? 1 : 2;
                @(negedge clk);
                if (m == 0) begin
                    m0_cyc = 1; m0_stb = 1; m0_adr = adr; m0_we = n[0];
                    m0_sel = n[3:0]; m0_cti = n[2:0]; m0_wdat = ~adr;
                end else begin
                    m1_cyc = 1; m1_stb = 1; m1_adr = adr; m1_we = n[0];
                    m1_sel = n[3:0]; m1_cti = n[2:0]; m1_wdat = ~adr;
                end
                tick();
                chk(a_cyc == NS'(1 << idx), "R4 slave select", a_cyc, 1 << idx);
                chk(a_stb == NS'(1 << idx), "R5 strobe to selected only", a_stb, 1 << idx);
                chk(a_adr == adr && a_wdat == ~adr, "R5 shared address and data",
                    {a_adr, a_wdat}, {adr, ~adr});
                chk(a_we == n[0] && a_sel == n[3:0] && a_cti == n[2:0],
                    "R5 shared we/sel/cti", {a_we, a_sel, a_cti}, {n[0], n[3:0], n[2:0]});
                if (m == 0) begin
                    chk(a_m0_ack && a_m0_rdat == 32'hC0DE_0000 + idx, "R6 ack and data to m0",
                        {a_m0_ack, a_m0_rdat}, {1'b1, 32'hC0DE_0000 + idx});
                    chk(!a_m1_ack && a_m1_rdat == 0, "R6 other master quiet",
                        {a_m1_ack, a_m1_rdat}, 0);
                end else begin
                    chk(a_m1_ack && a_m1_rdat == 32'hC0DE_0000 + idx, "R6 ack and data to m1",
                        {a_m1_ack, a_m1_rdat}, {1'b1, 32'hC0DE_0000 + idx});
                    chk(!a_m0_ack && a_m0_rdat == 0, "R6 other master quiet",
                        {a_m0_ack, a_m0_rdat}, 0);
                end
                @(negedge clk);
                m0_cyc = 0; m0_stb = 0; m1_cyc = 0; m1_stb = 0;
                @(posedge clk);
            end
        end

        // R2: simultaneous request from idle
        @(negedge clk);
        m0_cyc = 1; m0_stb = 1; m0_adr = 32'h0000_0010;
        m1_cyc = 1; m1_stb = 1; m1_adr = 32'h1000_0020;
        tick();
        chk(a_cyc == 3'b001 && a_m0_ack, "R2 master 0 wins", {a_cyc, a_m0_ack}, {3'b001, 1'b1});
        chk(!a_m1_ack && a_m1_rdat == 0, "R2 master 1 waits", {a_m1_ack, a_m1_rdat}, 0);
        tick();
        chk(a_cyc == 3'b001, "R3 master 0 holds", a_cyc, 3'b001);
        @(negedge clk);
        m0_cyc = 0; m0_stb = 0;
        tick();
        chk(a_cyc == 0 && !a_m1_ack, "R3 idle gap", {a_cyc, a_m1_ack}, 0);
        tick();
        chk(a_cyc == 3'b010 && a_m1_ack && a_m1_rdat == 32'hC0DE_0001, "R3 master 1 granted",
            {a_cyc, a_m1_ack, a_m1_rdat}, {3'b010, 1'b1, 32'hC0DE_0001});
        @(negedge clk);
        m0_cyc = 1; m0_stb = 1;
        tick();
        chk(a_cyc == 3'b010 && !a_m0_ack, "R3 no pre-emption", {a_cyc, a_m0_ack}, {3'b010, 1'b0});
        tick();
        chk(a_cyc == 3'b010 && !a_m0_ack, "R3 no pre-emption later", {a_cyc, a_m0_ack},
            {3'b010, 1'b0});
        @(negedge clk);
        m0_cyc = 0; m0_stb = 0; m1_cyc = 0; m1_stb = 0;
        @(posedge clk);

        // R6: error and retry routing from default slave
        @(negedge clk);
        ack_en = 0; err_en = 3'b100;
        m1_cyc = 1; m1_stb = 1; m1_adr = 32'h5000_0000;
        tick();
        chk(a_m1_err && !a_m0_err && !a_m1_ack, "R6 err to granted master",
            {a_m1_err, a_m0_err, a_m1_ack}, 3'b100);
        @(negedge clk);
        err_en = 0; rty_en = 3'b100;
        #1;
        chk(a_m1_rty && !a_m0_rty && !a_m1_err, "R6 rty to granted master",
            {a_m1_rty, a_m0_rty, a_m1_err}, 3'b100);
        @(negedge clk);
        rty_en = 0; m1_cyc = 0; m1_stb = 0;
        @(posedge clk);

        // R7: watchdog on a stalled strobe
        @(negedge clk);
        m0_cyc = 1; m0_stb = 1; m0_adr = 32'h0000_0100;
        @(posedge clk);
        repeat (14) @(posedge clk);
        #1;
        chk(!a_m0_err, "R7 no err before terminal count", a_m0_err, 0);
        tick();
        chk(a_m0_err && !a_m1_err, "R7 err at terminal count", {a_m0_err, a_m1_err}, 2'b10);
        tick();
        chk(!a_m0_err, "R7 err lasts one cycle", a_m0_err, 0);

        // R9: dropping stb restarts the count
        repeat (8) @(posedge clk);
        @(negedge clk) m0_stb = 0;
        @(posedge clk);
        @(negedge clk) m0_stb = 1;
        repeat (13) @(posedge clk);
        #1;
        chk(!a_m0_err, "R9 count restarted", a_m0_err, 0);
        tick();
        chk(!a_m0_err, "R9 one cycle before expiry", a_m0_err, 0);
        tick();
        chk(a_m0_err, "R9 expiry after full window", a_m0_err, 1);
        @(negedge clk);
        m0_cyc = 0; m0_stb = 0; ack_en = '1;
        @(posedge clk);
        @(posedge clk);

        // R8: registered request path
        @(negedge clk);
        m0_cyc = 1; m0_stb = 1; m0_adr = 32'h0000_0040; m0_cti = 3'b000;
        tick();
        chk(b_stb == 0 && !b_m0_ack, "R8 no strobe on grant cycle", {b_stb, b_m0_ack}, 0);
        chk(a_stb == 3'b001, "R8 unregistered path already strobes", a_stb, 3'b001);
        tick();
        chk(b_stb == 3'b001 && b_adr == 32'h0000_0040, "R8 delayed strobe and address",
            {b_stb, b_adr}, {3'b001, 32'h0000_0040});
        chk(b_m0_ack && b_m0_rdat == 32'hC0DE_0000, "R8 unregistered response",
            {b_m0_ack, b_m0_rdat}, {1'b1, 32'hC0DE_0000});
        tick();
        chk(b_stb == 0 && b_cyc == 3'b001, "R8 strobe dropped after response",
            {b_stb, b_cyc}, {3'b000, 3'b001});
        @(negedge clk);
        m0_cyc = 0; m0_stb = 0;
        tick();
        tick();
        chk(b_cyc == 0, "R8 cycle released", b_cyc, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule